// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial PCM stream into parallel samples. It watches a bit clock, a word-select clock and one data line, all of them asynchronous to the system clock. It brings the three lines into the system clock domain and detects each rising edge of the bit clock. From the words it assembles, it presents a left and a right 24-bit sample. A two-bit format input chooses one of four framings. Two are right-aligned to the end of the half-frame (16-bit and 24-bit). One is left-aligned to the word-select edge. The last is the one-bit-delayed I2S framing.

The right-aligned modes cannot know where the word starts, so they keep the most recent bits in a shift register and take the word when the word-select line changes. The left-aligned and I2S modes count bit positions from the word-select edge. Sixteen-bit results are placed in the upper bits of the 24-bit output and the low byte is zero. A one-cycle strobe marks each completed pair, and both output words change only on that cycle. The first half-frame after reset is treated as partial and is discarded.

Top module: `audio_serial_rx`

## Requirements
- R1: While reset is asserted and on the cycle after it, `leftWord` and `rightWord` are zero and `pairValid` is low.
- R2: Format 0 (16-bit right-aligned): the last 16 bits before each word-select change form the word. The word is output as bits 23:8, with bits 7:0 zero. This works at 32 and 64 bit clocks per frame.
- R3: Format 1 (24-bit right-aligned): the last 24 bits before each word-select change form the word. This works at 48 and 64 bit clocks per frame.
- R4: Format 2 (24-bit left-aligned): the bit sampled on the first bit-clock rise after a word-select change is the MSB, and the next 23 bits follow. This works at 48 and 64 bit clocks per frame.
- R5: Format 3 (I2S): the MSB arrives on the second bit-clock rise after a word-select change, and the left channel is carried while word-select is low. This is the format the bench uses after power-up.
- R6: Format 3 at 32 bit clocks per frame yields 16-bit words. These are output in bits 23:8, with bits 7:0 zero.
- R7: In formats 0, 1 and 2, the left channel is carried while word-select is high.
- R8: Data bits outside the word window of a half-frame have no effect on either output word.
- R9: `pairValid` is a single-cycle pulse after each right word. Both output words hold their values on every cycle without the pulse. No pulse results from the half-frame in progress when the stream starts.
- R10: All data is MSB first and two's complement, and is sampled on the bit-clock rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock, asynchronous |
| wordSel | input | 1 | Word-select (channel) clock, asynchronous |
| serData | input | 1 | Serial data line |
| fmtSel | input | 2 | Framing: 0 LSB16, 1 LSB24, 2 MSB24, 3 I2S |
| leftWord | output | 24 | Last completed left sample |
| rightWord | output | 24 | Last completed right sample |
| pairValid | output | 1 | One-cycle strobe when a stereo pair is updated |

## Verification
The bench fills every bit outside the word window with random values. A receiver that opened its window one bit early or late would then read garbage into the MSB or LSB. It also uses full-scale positive and negative samples and the all-zero and all-one patterns, where an off-by-one or a sign slip shows up at once. It runs each format at its shortest and longest frame: with right-aligned 16-bit data at 64 clocks, a counting design would latch the padding bits. For I2S, a design that forgot the one-bit delay would report every word shifted by one bit, and a design with the wrong channel polarity would swap left and right. The bench also counts pulses, so a spurious pair from the partial first half-frame is caught.

// File: rtl/audio_serial_rx_pkg.sv
package audio_serial_rx_pkg;
  localparam logic [1:0] FMT_LSB16 = 2'd0;
  localparam logic [1:0] FMT_LSB24 = 2'd1;
  localparam logic [1:0] FMT_MSB24 = 2'd2;
  localparam logic [1:0] FMT_I2S   = 2'd3;

  typedef struct packed {
    logic bitTick;   // synchronized bit-clock rising edge
    logic lrEdge;    // word-select changed at this tick
    logic leftDone;  // a left half-frame has just ended (armed)
    logic rightDone; // a right half-frame has just ended (armed)
    logic dataBit;   // data bit sampled with this tick
  } rxStrobes_t;
endpackage

// File: rtl/audio_serial_rx_ctrl.sv
module audio_serial_rx_ctrl
  import audio_serial_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       wordSel,
  input  logic       serData,
  input  logic [1:0] fmtSel,
  output rxStrobes_t strobes
);
  localparam int BW = SYNC_STAGES + 1;

  logic [BW-1:0]          bitPipe;
  logic [SYNC_STAGES-1:0] lrPipe;
  logic [SYNC_STAGES-1:0] datPipe;
  logic lrPrev, seenTick, armed;
  logic tickNow, lrNow, edgeNow, leftLevel, capture;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitPipe <= '0;
      lrPipe  <= '0;
      datPipe <= '0;
    end else begin
      bitPipe <= {bitPipe[BW-2:0], bitClk};
      lrPipe  <= {lrPipe[SYNC_STAGES-2:0], wordSel};
      datPipe <= {datPipe[SYNC_STAGES-2:0], serData};
    end
  end

  always_comb begin
    tickNow   = bitPipe[BW-2] & ~bitPipe[BW-1];
    lrNow     = lrPipe[SYNC_STAGES-1];
    edgeNow   = tickNow & seenTick & (lrNow != lrPrev);
    leftLevel = (fmtSel != FMT_I2S);
    capture   = edgeNow & armed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lrPrev   <= 1'b0;
      seenTick <= 1'b0;
      armed    <= 1'b0;
    end else if (tickNow) begin
      lrPrev   <= lrNow;
      seenTick <= 1'b1;
      if (edgeNow) armed <= 1'b1;
    end
  end

  always_comb begin
    strobes.bitTick   = tickNow;
    strobes.lrEdge    = edgeNow;
    strobes.leftDone  = capture & (lrPrev == leftLevel);
    strobes.rightDone = capture & (lrPrev != leftLevel);
    strobes.dataBit   = datPipe[SYNC_STAGES-1];
  end
endmodule

// File: rtl/audio_serial_rx_dp.sv
module audio_serial_rx_dp
  import audio_serial_rx_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        fmtSel,
  input  rxStrobes_t        strobes,
  output logic [WORD_W-1:0] leftWord,
  output logic [WORD_W-1:0] rightWord,
  output logic              pairValid
);
  localparam int CW  = $clog2(WORD_W + 1);
  localparam int PAD = WORD_W - SHORT_W;
  localparam logic [CW-1:0] FULL = CW'(WORD_W);

  logic [WORD_W-1:0] shiftReg;   // most recent bits, for right-aligned modes
  logic [WORD_W-1:0] msbAcc;     // bits placed from the MSB down
  logic [CW-1:0]     bitCnt;     // bits placed since the edge
  logic [WORD_W-1:0] leftStage;
  logic [WORD_W-1:0] i2sWord;
  logic [WORD_W-1:0] capWord;

  always_comb begin
    i2sWord = msbAcc;
    if (bitCnt < FULL) i2sWord[WORD_W-1-int'(bitCnt)] = strobes.dataBit;
    unique case (fmtSel)
      FMT_LSB16: capWord = {shiftReg[SHORT_W-1:0], {PAD{1'b0}}};
      FMT_LSB24: capWord = shiftReg;
      FMT_MSB24: capWord = msbAcc;
      default:   capWord = i2sWord;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      msbAcc   <= '0;
      bitCnt   <= '0;
    end else if (strobes.bitTick) begin
      shiftReg <= {shiftReg[WORD_W-2:0], strobes.dataBit};
      if (strobes.lrEdge) begin
        if (fmtSel == FMT_I2S) begin
          msbAcc <= '0;
          bitCnt <= '0;
        end else begin
          msbAcc <= {strobes.dataBit, {(WORD_W-1){1'b0}}};
          bitCnt <= CW'(1);
        end
      end else if (bitCnt < FULL) begin
        msbAcc[WORD_W-1-int'(bitCnt)] <= strobes.dataBit;
        bitCnt <= bitCnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      leftStage <= '0;
      leftWord  <= '0;
      rightWord <= '0;
      pairValid <= 1'b0;
    end else begin
      pairValid <= 1'b0;
      if (strobes.leftDone) leftStage <= capWord;
      if (strobes.rightDone) begin
        leftWord  <= leftStage;
        rightWord <= capWord;
        pairValid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
  import audio_serial_rx_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              wordSel,
  input  logic              serData,
  input  logic [1:0]        fmtSel,
  output logic [WORD_W-1:0] leftWord,
  output logic [WORD_W-1:0] rightWord,
  output logic              pairValid
);
  rxStrobes_t strobes;

  audio_serial_rx_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordSel(wordSel),
    .serData(serData), .fmtSel(fmtSel), .strobes(strobes)
  );

  audio_serial_rx_dp #(.WORD_W(WORD_W), .SHORT_W(SHORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .strobes(strobes),
    .leftWord(leftWord), .rightWord(rightWord), .pairValid(pairValid)
  );
endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        fmtSel,
  input logic [WORD_W-1:0] leftWord,
  input logic [WORD_W-1:0] rightWord,
  input logic              pairValid
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (leftWord == '0 && rightWord == '0 && !pairValid));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    pairValid |=> !pairValid);

  p_words_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pairValid |-> ($stable(leftWord) && $stable(rightWord)));

  p_zero_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pairValid && fmtSel == 2'd0) |-> (leftWord[7:0] == 8'd0 && rightWord[7:0] == 8'd0));
endmodule

bind audio_serial_rx audio_serial_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .leftWord(leftWord),
  .rightWord(rightWord), .pairValid(pairValid)
);

// File: tb/audio_serial_rx_tb.sv
`timescale 1ns/1ps
module audio_serial_rx_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b0;
  logic wordSel = 1'b0;
  logic serData = 1'b0;
  logic [1:0] fmtSel = 2'd3;
  logic [23:0] leftWord, rightWord;
  logic pairValid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curTag = "";
  logic [23:0] expL [0:63];
  logic [23:0] expR [0:63];
  int wrIdx = 0;
  int rdIdx = 0;
  logic prevNom = 1'b0;

  always #2 clk = ~clk;

  audio_serial_rx u_dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .wordSel(wordSel),
    .serData(serData), .fmtSel(fmtSel), .leftWord(leftWord),
    .rightWord(rightWord), .pairValid(pairValid)
  );

  function automatic logic [23:0] expWord(int f, int h, logic [23:0] s);
    if (f == 0 || (f == 3 && h == 16)) return {s[23:8], 8'h00};
    return s;
  endfunction

  function automatic logic nomBit(int f, int h, int i, logic [23:0] s, logic junk);
    case (f)
      0: return (i >= h - 16) ? s[23 - (i - (h - 16))] : junk;
      1: return (i >= h - 24) ? s[23 - (i - (h - 24))] : junk;
      2: return (i < 24) ? s[23 - i] : junk;
      default: return (i < ((h == 16) ? 16 : 24)) ? s[23 - i] : junk;
    endcase
  endfunction

  task automatic check(string what, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", curTag, what, got, exp);
    end
  endtask

  // one bit: word-select and data change while the bit clock is low
  task automatic sendBit(int f, logic lr, logic nom);
    wordSel = lr;
    serData = (f == 3) ? prevNom : nom;
    prevNom = nom;
    #16 bitClk = 1'b1;
    #16 bitClk = 1'b0;
  endtask

  task automatic sendHalf(int f, int h, logic lr, logic [23:0] s);
    for (int i = 0; i < h; i++) sendBit(f, lr, nomBit(f, h, i, s, 1'($urandom)));
  endtask

  always @(negedge clk) begin
    if (rstN && pairValid && !done) begin
      if (rdIdx < wrIdx) begin
        check("left", leftWord, expL[rdIdx]);
        check("right", rightWord, expR[rdIdx]);
        rdIdx++;
      end else begin
        checks++; errors++;
        $display("FAIL %s R9 unexpected pair got %h/%h expected none", curTag, leftWord, rightWord);
      end
    end
  end

  task automatic runCase(int f, int ratio, int nFrames, string tag);
    int h = ratio / 2;
    logic leftLvl = (f != 3);
    logic [23:0] sL, sR;
    curTag = tag;
    rstN = 1'b0; fmtSel = 2'(f); bitClk = 1'b0; wordSel = ~leftLvl; prevNom = 1'b0;
    wrIdx = 0; rdIdx = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);
    sendHalf(f, h, ~leftLvl, 24'($urandom));   // partial lead-in, must not pair
    for (int fr = 0; fr < nFrames; fr++) begin
      if (fr == 0) begin sL = 24'h800000; sR = 24'h7FFFFF; end
      else if (fr == 1) begin sL = 24'h000000; sR = 24'hFFFFFF; end
      else begin sL = 24'($urandom); sR = 24'($urandom); end
      expL[wrIdx] = expWord(f, h, sL);
      expR[wrIdx] = expWord(f, h, sR);
      wrIdx++;
      sendHalf(f, h, leftLvl, sL);
      sendHalf(f, h, ~leftLvl, sR);
    end
    sendHalf(f, h, leftLvl, 24'($urandom));     // closes the last right word
    repeat (20) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rdIdx != wrIdx) begin
      errors++;
      $display("FAIL %s R9 pair count got %0d expected %0d", tag, rdIdx, wrIdx);
    end
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk);
    curTag = "R1";
    check("reset left", leftWord, 24'h0);
    check("reset right", rightWord, 24'h0);
    check("reset valid", {23'h0, pairValid}, 24'h0);
    runCase(3, 64, 6, "R5 R10 R8 I2S64");
    runCase(3, 48, 6, "R5 R10 I2S48");
    runCase(3, 32, 6, "R6 R5 I2S32");
    runCase(0, 32, 6, "R2 R7 LSB16x32");
    runCase(0, 64, 6, "R2 R8 R7 LSB16x64");
    runCase(1, 48, 6, "R3 R7 LSB24x48");
    runCase(1, 64, 6, "R3 R8 LSB24x64");
    runCase(2, 48, 6, "R4 R7 R10 MSB24x48");
    runCase(2, 64, 6, "R4 R8 MSB24x64");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      done = 1;
      $display("FAIL watchdog expired got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule